// File: doc/BRIEF.md
# Multi-Thread Gate Control Scheduler

This block is the time-aware egress gate engine of a small Ethernet switch. One linear table of gate-control slots serves every port. Each slot holds a duration in ticks, a set of destination ports, and a mask of traffic classes to close, together with a bit that enables that mask. Up to eight execution threads each walk their own contiguous slice of the table. A thread starts at its entry address, keeps each slot in force for that slot's duration, and jumps back to its entry address after its end slot. It repeats this until the scheduler is disabled. For every port the block drives an eight-bit vector of open traffic-class gates.

Software loads the slot table, the per-thread entry records (start address and start offset), the per-thread end indices, the active-thread count, the base time and the time-source select. All of these go through one register-style write port. Loading is allowed only while the scheduler is disabled. Enabling it starts a fresh run from the beginning. A prescaler divides the core clock into 200 ns ticks. Slot durations are always counted in these ticks. The time that gates a thread's start comes from an internal tick counter or from one of two external time inputs, as the time-source select chooses. A gate state is applied whether or not a frame would fit before the next change: there is no guard band.

Top module: `tas_gate_sched`

## Requirements
- R1: A slot write (cfg_sel=0, cfg_addr=slot) takes cfg_wdata[18:0] as the duration, [26:19] as the closed-class mask, [27] as the mask enable and [32:28] as the port set. A port served by a slot whose mask enable is 1 sees the complement of the mask; with the enable at 0 it sees all eight gates open.
- R2: A thread write with cfg_sel=1 takes cfg_wdata[18:0] as the start offset and [24:19] as the start address. A write with cfg_sel=2 takes [5:0] as the end index. A global write with cfg_sel=3 and cfg_addr=0 takes [1:0] as the time source and [4:2] as the active count minus one. A global write with cfg_sel=3 and cfg_addr=1 takes [31:0] as the base time. For all thread writes, cfg_addr[2:0] selects the thread.
- R3: Time source 0 disables the scheduler. Source 1 uses an internal tick count that starts at zero on enable. Source 2 uses sync_time. Source 3 uses ptp_time.
- R4: An active thread starts on the first clock edge at which the selected time is greater than or equal to base time plus its start offset. It does not start before that edge.
- R5: A running thread steps through its slots from its start address to its end index, then wraps back to its start address and repeats.
- R6: A tick lasts TICK_DIV core clocks. Each slot stays in force for exactly its duration in ticks.
- R7: Threads numbered above the programmed active count minus one never start.
- R8: A port that no running thread's current slot names has all eight gates open. This is also the state after reset.
- R9: When several running threads name the same port, the lowest-numbered thread sets its gates.
- R10: While the scheduler is enabled, writes to slots, thread records, end indices, the base time and the active count are ignored. A global write with cfg_addr=0 always updates the time source.
- R11: Writing time source 0 opens every gate from the next cycle on. Re-enabling restarts every thread from its entry point with the internal time at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 slot, 1 thread record, 2 end index, 3 global |
| cfg_addr | input | AW (6) | Slot index, or thread number in the low bits, or global register |
| cfg_wdata | input | WD (33) | Write data |
| sync_time | input | TW (32) | External synchronized time in ticks |
| ptp_time | input | TW (32) | External precision time in ticks |
| gate_open | output | NUM_PORTS*8 (40) | Open-gate vector, port p in bits [8p+7:8p] |

## Verification
A thread index that leaves its slice, or a remaining-tick count that is off by one, shows up on gate_open within one slot duration. Both change which gate vector appears at the first boundary that follows. Repeated loops then shift the error further each time. A wrong start condition shows up as a thread whose gates appear one tick period early or late. A wrong priority shows up as soon as two threads name the same port. The bench models each thread from the number of ticks elapsed since its start edge, reduced modulo its loop length. It compares all ports every cycle, so any such drift is reported within the cycle it first appears.

// File: rtl/tas_gate_sched_pkg.sv
package tas_gate_sched_pkg;
  localparam int TC = 8;   // traffic classes per port
  localparam int DW = 19;  // slot duration / offset width in ticks

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_FREE = 2'd1,
    SRC_SYNC = 2'd2,
    SRC_PTP  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    SEL_SLOT  = 2'd0,
    SEL_ENTRY = 2'd1,
    SEL_END   = 2'd2,
    SEL_GLOB  = 2'd3
  } sel_e;

  // gates left open by one slot
  function automatic logic [TC-1:0] open_gates(input logic mask_en, input logic [TC-1:0] closed);
    return mask_en ? ~closed : {TC{1'b1}};
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tas_gate_sched_timebase.sv
module tas_gate_sched_timebase #(
  parameter int TICK_DIV = 50,
  parameter int TW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    src,
  input  logic [TW-1:0] sync_time,
  input  logic [TW-1:0] ptp_time,
  output logic          tick,
  output logic [TW-1:0] now
);
  import tas_gate_sched_pkg::*;
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;
  logic [TW-1:0] free_q;

  assign tick = en && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      free_q <= '0;
    end else if (!en) begin
      div_q  <= '0;
      free_q <= '0;
    end else begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + CW'(1);
      if (tick) free_q <= free_q + TW'(1);
    end
  end

  always_comb begin
    case (src)
      SRC_FREE: now = free_q;
      SRC_SYNC: now = sync_time;
      SRC_PTP:  now = ptp_time;
      default:  now = '0;
    endcase
  end

  // R6: ticks are spaced by the divider
  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (TICK_DIV > 1)) |=> !tick);
endmodule

// File: rtl/tas_gate_sched_thread.sv
module tas_gate_sched_thread #(
  parameter int AW = 6,
  parameter int TW = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic                               act,
  input  logic                               tick,
  input  logic [TW-1:0]                      now,
  input  logic [TW-1:0]                      base_time,
  input  logic [tas_gate_sched_pkg::DW-1:0]  offset,
  input  logic [AW-1:0]                      start_addr,
  input  logic [AW-1:0]                      end_addr,
  input  logic [tas_gate_sched_pkg::DW-1:0]  nxt_delta,
  output logic                               running,
  output logic [AW-1:0]                      cur_idx,
  output logic [AW-1:0]                      nxt_idx
);
  import tas_gate_sched_pkg::*;

  logic [DW-1:0] remain_q;
  logic          time_ok;
  logic          start_now;
  logic          last_tick;

  assign time_ok   = now >= (base_time + TW'(offset));
  assign start_now = en && act && !running && time_ok;
  assign last_tick = running && tick && (remain_q <= DW'(1));
  assign nxt_idx   = (!running || cur_idx == end_addr) ? start_addr : cur_idx + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cur_idx  <= '0;
      remain_q <= '0;
    end else if (!en) begin
      running <= 1'b0;
    end else if (start_now) begin
      running  <= 1'b1;
      cur_idx  <= start_addr;
      remain_q <= nxt_delta;
    end else if (last_tick) begin
      cur_idx  <= nxt_idx;
      remain_q <= nxt_delta;
    end else if (running && tick) begin
      remain_q <= remain_q - DW'(1);
    end
  end

  // R4: a thread only begins once its time has come
  p_start_on_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(time_ok && act));
  // R5: the slot index never leaves the thread's slice
  p_stay_in_slice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_addr <= end_addr) |-> (cur_idx >= start_addr && cur_idx <= end_addr));
  // R6: no slot change before its last tick
  p_hold_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && remain_q > DW'(1)) |=> $stable(cur_idx));
  // R7: inactive threads stay idle
  p_idle_thread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !act) |-> !running);
  // R11: disabling stops every thread
  p_off_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running);
endmodule

// File: rtl/tas_gate_sched_merge.sv
module tas_gate_sched_merge #(
  parameter int NP = 5,
  parameter int NT = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       en,
  input  logic [NT-1:0]                              running,
  input  logic [NT-1:0][NP-1:0]                      thr_ports,
  input  logic [NT-1:0][tas_gate_sched_pkg::TC-1:0]  thr_gates,
  output logic [NP*tas_gate_sched_pkg::TC-1:0]       gate_open
);
  import tas_gate_sched_pkg::*;

  logic [NP-1:0][NT-1:0] hit;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic [TC-1:0] vec;
      vec = '1;
      for (int t = NT - 1; t >= 0; t--) begin
        hit[p][t] = en && running[t] && thr_ports[t][p];
        if (hit[p][t]) vec = thr_gates[t];
      end
      gate_open[p*TC +: TC] = vec;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R8: uncovered ports stay fully open
    p_uncovered_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|hit[p]) |-> (gate_open[p*TC +: TC] == {TC{1'b1}}));
    // R9: thread 0 overrides every other thread
    p_low_thread_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[p][0] |-> (gate_open[p*TC +: TC] == thr_gates[0]));
  end
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_gate_sched_pkg::*;
#(
  parameter int NUM_PORTS   = 5,
  parameter int NUM_THREADS = 8,
  parameter int DEPTH       = 64,
  parameter int TICK_DIV    = 50,
  parameter int TW          = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int TIDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLW  = DW + TC + 1 + NUM_PORTS,
  localparam int WD   = imax(imax(SLW, DW + AW), imax(TW, 2 + TIDW))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [WD-1:0]             cfg_wdata,
  input  logic [TW-1:0]             sync_time,
  input  logic [TW-1:0]             ptp_time,
  output logic [NUM_PORTS*TC-1:0]   gate_open
);
  localparam int NT = NUM_THREADS;
  localparam int NP = NUM_PORTS;

  logic [DEPTH-1:0][DW-1:0] slot_delta;
  logic [DEPTH-1:0][TC-1:0] slot_closed;
  logic [DEPTH-1:0]         slot_men;
  logic [DEPTH-1:0][NP-1:0] slot_ports;
  logic [NT-1:0][DW-1:0]    ep_off;
  logic [NT-1:0][AW-1:0]    ep_start;
  logic [NT-1:0][AW-1:0]    end_idx;
  logic [1:0]               src_q;
  logic [TIDW-1:0]          actm1_q;
  logic [TW-1:0]            base_q;

  logic                     en;
  logic                     tick;
  logic [TW-1:0]            now;
  logic [NT-1:0]            thr_act;
  logic [NT-1:0]            thr_run;
  logic [NT-1:0][AW-1:0]    cur_idx;
  logic [NT-1:0][AW-1:0]    nxt_idx;
  logic [NT-1:0][DW-1:0]    nxt_delta;
  logic [NT-1:0][NP-1:0]    thr_ports;
  logic [NT-1:0][TC-1:0]    thr_gates;
  logic [TIDW-1:0]          wr_thr;

  assign en     = (src_q != SRC_OFF);
  assign wr_thr = cfg_addr[TIDW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_delta  <= '0;
      slot_closed <= '0;
      slot_men    <= '0;
      slot_ports  <= '0;
      ep_off      <= '0;
      ep_start    <= '0;
      end_idx     <= '0;
      src_q       <= SRC_OFF;
      actm1_q     <= '0;
      base_q      <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_SLOT: if (!en) begin
          slot_delta[cfg_addr]  <= cfg_wdata[DW-1:0];
          slot_closed[cfg_addr] <= cfg_wdata[DW +: TC];
          slot_men[cfg_addr]    <= cfg_wdata[DW + TC];
          slot_ports[cfg_addr]  <= cfg_wdata[DW + TC + 1 +: NP];
        end
        SEL_ENTRY: if (!en) begin
          ep_off[wr_thr]   <= cfg_wdata[DW-1:0];
          ep_start[wr_thr] <= cfg_wdata[DW +: AW];
        end
        SEL_END: if (!en) end_idx[wr_thr] <= cfg_wdata[AW-1:0];
        default: begin
          if (cfg_addr == '0) begin
            src_q <= cfg_wdata[1:0];
            if (!en) actm1_q <= cfg_wdata[2 +: TIDW];
          end else if (!en) begin
            base_q <= cfg_wdata[TW-1:0];
          end
        end
      endcase
    end
  end

  tas_gate_sched_timebase #(.TICK_DIV(TICK_DIV), .TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .src(src_q),
    .sync_time(sync_time), .ptp_time(ptp_time), .tick(tick), .now(now)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign thr_act[t]   = (TIDW'(t) <= actm1_q);
    assign nxt_delta[t] = slot_delta[nxt_idx[t]];
    assign thr_ports[t] = slot_ports[cur_idx[t]];
    assign thr_gates[t] = open_gates(slot_men[cur_idx[t]], slot_closed[cur_idx[t]]);

    tas_gate_sched_thread #(.AW(AW), .TW(TW)) u_thr (
      .clk(clk), .rst_n(rst_n), .en(en), .act(thr_act[t]), .tick(tick),
      .now(now), .base_time(base_q), .offset(ep_off[t]),
      .start_addr(ep_start[t]), .end_addr(end_idx[t]), .nxt_delta(nxt_delta[t]),
      .running(thr_run[t]), .cur_idx(cur_idx[t]), .nxt_idx(nxt_idx[t])
    );
  end

  tas_gate_sched_merge #(.NP(NP), .NT(NT)) u_merge (
    .clk(clk), .rst_n(rst_n), .en(en), .running(thr_run),
    .thr_ports(thr_ports), .thr_gates(thr_gates), .gate_open(gate_open)
  );

  // R10: configuration is frozen while the scheduler runs
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> ($stable(slot_delta) && $stable(slot_closed) && $stable(slot_men)
      && $stable(slot_ports) && $stable(ep_start) && $stable(ep_off) && $stable(end_idx)
      && $stable(base_q) && $stable(actm1_q)));
  // R11: gates all open once disabled
  p_disabled_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate_open == {NP*TC{1'b1}}));
endmodule

// File: tb/tas_gate_sched_test.sv
module tas_gate_sched_test;
  localparam int NP = 5, NT = 8, DEPTH = 64, TD = 4, TW = 32, AW = 6, WD = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [AW-1:0]    cfg_addr = '0;
  logic [WD-1:0]    cfg_wdata = '0;
  logic [TW-1:0]    sync_time = '0;
  logic [TW-1:0]    ptp_time = '0;
  logic [NP*8-1:0]  gate_open;

  tas_gate_sched #(.NUM_PORTS(NP), .NUM_THREADS(NT), .DEPTH(DEPTH), .TICK_DIV(TD), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_time(sync_time), .ptp_time(ptp_time), .gate_open(gate_open)
  );

  int n_chk = 0, n_bad = 0, mcnt = 0;
  bit done = 0;

  int           b_delta [DEPTH];
  logic [7:0]   b_closed[DEPTH];
  bit           b_men   [DEPTH];
  logic [NP-1:0] b_ports[DEPTH];
  int b_start[NT], b_end[NT], b_off[NT];
  int b_actm1 = 0, b_base = 0;

  // expected gates of one port, m clocks after the enabling edge (internal time source)
  function automatic logic [7:0] exp_port(int p, int m);
    for (int t = 0; t <= b_actm1; t++) begin
      int ms = TD * (b_base + b_off[t]) + 1;
      if (m >= ms) begin
        int n = (m - ms + 1) / TD;
        int total = 0;
        int pos, k;
        for (int j = b_start[t]; j <= b_end[t]; j++) total += b_delta[j];
        pos = n % total;
        k = b_start[t];
        while (pos >= b_delta[k]) begin
          pos -= b_delta[k];
          k++;
        end
        if (b_ports[k][p]) return b_men[k] ? ~b_closed[k] : 8'hFF;
      end
    end
    return 8'hFF;
  endfunction

  function automatic logic [NP*8-1:0] exp_all(int m);
    logic [NP*8-1:0] v;
    for (int p = 0; p < NP; p++) v[p*8 +: 8] = exp_port(p, m);
    return v;
  endfunction

  task automatic chk(logic [NP*8-1:0] got, logic [NP*8-1:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at m=%0d: got %h expected %h", tag, mcnt, got, exp);
    end
  endtask

  task automatic chk8(int p, logic [7:0] exp, string tag);
    n_chk++;
    if (gate_open[p*8 +: 8] !== exp) begin
      n_bad++;
      $display("FAIL %s port %0d: got %h expected %h", tag, p, gate_open[p*8 +: 8], exp);
    end
  endtask

  task automatic wr(int sel, int addr, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_addr = addr[AW-1:0]; cfg_wdata = d[WD-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_slot(int k, int d, logic [7:0] cl, bit mn, logic [NP-1:0] pm);
    b_delta[k] = d; b_closed[k] = cl; b_men[k] = mn; b_ports[k] = pm;
    wr(0, k, 64'({pm, mn, cl, 19'(d)}));
  endtask

  task automatic put_thread(int t, int st, int en_i, int off);
    b_start[t] = st; b_end[t] = en_i; b_off[t] = off;
    wr(1, t, 64'({6'(st), 19'(off)}));
    wr(2, t, 64'(6'(en_i)));
  endtask

  task automatic set_base(int b);
    b_base = b;
    wr(3, 1, 64'(b));
  endtask

  task automatic start(int src, int actm1);
    b_actm1 = actm1;
    wr(3, 0, 64'({3'(actm1), 2'(src)}));
    mcnt = 0;
  endtask

  task automatic stop();
    wr(3, 0, 64'(0));
  endtask

  task automatic run(int n, string tag);
    repeat (n) begin
      @(negedge clk);
      mcnt++;
      chk(gate_open, exp_all(mcnt), tag);
    end
  endtask

  task automatic rand_round(int r);
    int k = 0;
    stop();
    for (int t = 0; t < NT; t++) begin
      int n = 1 + int'($urandom % 4);
      int st = k;
      for (int i = 0; i < n; i++) begin
        put_slot(k, 1 + int'($urandom % 5), 8'($urandom), ($urandom % 3) != 0, NP'($urandom));
        k++;
      end
      put_thread(t, st, k - 1, int'($urandom % 5));
    end
    set_base(int'($urandom % 3));
    start(1, int'($urandom % NT));
    run(150, "R5");
    if (r == 1) begin
      // R10: writes while enabled must not disturb the schedule
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = AW'(b_start[0]); cfg_wdata = WD'({$urandom, $urandom});
      run(1, "R10");
      cfg_sel = 2'd3; cfg_addr = '0; cfg_wdata = WD'({3'(b_actm1 ^ 7), 2'd1});
      run(1, "R10");
      cfg_addr = AW'(1); cfg_wdata = WD'(40);
      run(1, "R10");
      cfg_sel = 2'd1; cfg_addr = '0; cfg_wdata = WD'(12);
      run(1, "R10");
      cfg_we = 1'b0;
      run(60, "R10");
    end
    run(60, "R7");
    stop();
    chk(gate_open, '1, "R11");
    start(1, b_actm1);
    run(80, "R11");
  endtask

  initial begin
    void'($urandom(32'd91157));
    for (int k = 0; k < DEPTH; k++) begin
      b_delta[k] = 0; b_closed[k] = '0; b_men[k] = 0; b_ports[k] = '0;
    end
    for (int t = 0; t < NT; t++) begin
      b_start[t] = 0; b_end[t] = 0; b_off[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate_open, '1, "R8 reset");

    // R1 / R2: single slot with mask enabled, then disabled
    put_slot(0, 5, 8'h0F, 1, '1);
    put_thread(0, 0, 0, 0);
    set_base(0);
    start(1, 0);
    run(3, "R2");
    chk8(0, 8'hF0, "R1");
    chk8(4, 8'hF0, "R1");
    stop();
    chk(gate_open, '1, "R11");
    put_slot(0, 5, 8'h0F, 0, '1);
    start(1, 0);
    run(3, "R1");
    chk8(2, 8'hFF, "R1");
    stop();

    // R6 / R5: two slots of 3 and 2 ticks, wrap back
    put_slot(0, 3, 8'h01, 1, 5'b00001);
    put_slot(1, 2, 8'h02, 1, 5'b00001);
    put_thread(0, 0, 1, 0);
    start(1, 0);
    run(11, "R6");
    chk8(0, 8'hFE, "R6");
    run(1, "R6");
    chk8(0, 8'hFD, "R6");
    run(8, "R5");
    chk8(0, 8'hFE, "R5");
    run(40, "R6");
    stop();

    // R4: base 1 plus offset 2 -> start edge 13
    put_thread(0, 0, 1, 2);
    set_base(1);
    start(1, 0);
    run(12, "R4");
    chk8(0, 8'hFF, "R4");
    run(1, "R4");
    chk8(0, 8'hFE, "R4");
    stop();

    // R9 / R8: overlapping ports of threads 0 and 1
    put_slot(0, 4, 8'h01, 1, 5'b00011);
    put_slot(1, 4, 8'h02, 1, 5'b00110);
    put_thread(0, 0, 0, 0);
    put_thread(1, 1, 1, 0);
    set_base(0);
    start(1, 1);
    run(3, "R9");
    chk8(0, 8'hFE, "R9");
    chk8(1, 8'hFE, "R9");
    chk8(2, 8'hFD, "R9");
    chk8(3, 8'hFF, "R8");
    stop();

    // R7: thread 1 configured but not active
    start(1, 0);
    run(10, "R7");
    chk8(2, 8'hFF, "R7");
    stop();

    // R3: precision time source gates the start
    put_slot(0, 20, 8'h0F, 1, '1);
    set_base(10);
    ptp_time = 32'd5;
    start(3, 0);
    repeat (6) @(negedge clk);
    chk(gate_open, '1, "R4 ptp early");
    ptp_time = 32'd10;
    @(negedge clk);
    chk(gate_open, {NP{8'hF0}}, "R3 ptp");
    stop();

    // R3: synchronized time source
    sync_time = 32'd0;
    set_base(0);
    start(2, 0);
    @(negedge clk);
    chk(gate_open, {NP{8'hF0}}, "R3 sync");
    stop();
    chk(gate_open, '1, "R3 off");

    for (int r = 0; r < 6; r++) rand_round(r);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule